// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a serial-bus target that holds the configuration and identity bytes of a differential clock fan-out buffer. A host writes a burst of bytes by addressing the target with its write address, naming a starting register index and a byte count, and then sending that many data bytes. To read, the host sets the index the same way, issues a repeated start with the read address, and clocks bytes out. The first byte returned is the content of a writable count register. The bytes that follow come from consecutive registers, and the stream stops when the host answers a byte with a NACK.

SCL and SDA arrive already synchronized to `clk_i`. The target pulls SDA low by raising `sda_oe_o`, and the surrounding pad logic turns that into an open-drain driver. The decoded register fields leave the block as plain level outputs that steer the clock-control logic: power-down and halt drive modes, loop bandwidth, PLL or fan-out mode, divider select, per-output enables and per-output stoppable flags.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges address byte 0xDC (write) and 0xDD (read). Any other address byte is not acknowledged, and every bit that follows it is ignored until the next start or stop condition.
- R2: A write is built from the write address, an index byte N, a count byte X and data bytes. Each of these bytes is acknowledged, and the data bytes go to registers N, N+1, … N+X-1 in order.
- R3: A data byte that arrives after the X bytes announced by the count byte is not acknowledged and changes no register.
- R4: A read is a repeated start followed by 0xDD. The first byte returned equals register 6. After that come registers N, N+1, … in order, while the host acknowledges. A host NACK ends the transfer, and SDA is released once it is given.
- R5: Reset values are: register 0 = 0x07, register 1 = 0xFF, register 2 = 0x00, register 6 = 0x07.
- R6: Register 0 keeps only bits 7, 6, 2, 1 and 0. Bits 5..3 always read 0. Register 3 always reads 0x00.
- R7: Register 4 reads {REV_ID, 4'b0001} and register 5 reads DEV_ID. Writes to either register are acknowledged but change nothing.
- R8: Register 7 and every index from 8 to 255 read as 0x00.
- R9: A start condition seen in the middle of a byte discards that byte and begins a new address phase.
- R10: The target changes `sda_oe_o` only while SCL is low, and never pulls SDA while idle.
- R11: Field mapping. Register 0 bit 7 drives `pwrdn_hiz_o`, bit 6 drives `halt_hiz_o`, bit 2 drives `bw_low_o`, bit 1 drives `pll_mode_o` and bit 0 drives `div_full_o`. Register 1 bit n drives `out_en_o[n]`. Register 2 bit n drives `stoppable_o[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired line level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pwrdn_hiz_o | output | 1 | Power-down drive mode, 1 = both legs undriven |
| halt_hiz_o | output | 1 | Stop drive mode, 1 = both legs undriven |
| bw_low_o | output | 1 | 1 selects low loop bandwidth |
| pll_mode_o | output | 1 | 1 = PLL path, 0 = fan-out bypass |
| div_full_o | output | 1 | 1 = undivided, 0 = divide by two |
| out_en_o | output | NOUT | Per-output enable |
| stoppable_o | output | NOUT | Per-output stoppable (1) or free-running (0) |

## Verification
The bench targets the points where a target of this kind usually goes wrong. It sends data bytes past the announced count; a design that keeps writing would corrupt the next register. It writes to reserved bits and read-only identity bytes; a wrong write mask would show altered values on read-back. It reads from an index past the end of the file, where a design that wraps or aliases would return live register content instead of zero. It also sends a foreign address and a restart in the middle of a byte; a design that stays engaged would acknowledge or write bytes it should ignore. In the read stream it checks that the count byte comes before the data, because a design that skips it would shift every byte by one position.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDATA, ST_ACK, ST_TX, ST_HACK
  } smb_state_t;

  localparam int unsigned IDX_MODE = 0;
  localparam int unsigned IDX_EN   = 1;
  localparam int unsigned IDX_STOP = 2;
  localparam int unsigned IDX_CNT  = 6;

  // writable bits per register index
  function automatic logic [7:0] wr_mask(input int unsigned idx);
    case (idx)
      0:       return 8'hC7;
      1, 2, 6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_cond_det.sv
module smb_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_cfg_pkg::*; #(
  parameter int unsigned NOUT   = 8,
  parameter logic [3:0]  REV_ID = 4'h2,
  parameter logic [7:0]  DEV_ID = 8'h81
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [7:0]      idx_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic [7:0]      cnt_o,
  output logic [7:0]      mode_o,
  output logic [NOUT-1:0] en_o,
  output logic [NOUT-1:0] stop_sel_o
);
  localparam int unsigned NREG = 8;
  localparam int unsigned IW   = $clog2(NREG);

  logic [7:0] regs [NREG];
  logic       in_range;

  function automatic logic [7:0] rst_val(input int unsigned idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      4:       return {REV_ID, 4'b0001};
      5:       return DEV_ID;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  assign in_range = (idx_i < 8'(NREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else if (wr_en_i && in_range) begin
      regs[idx_i[IW-1:0]] <= (wdata_i & wr_mask(int'(idx_i))) |
                             (regs[idx_i[IW-1:0]] & ~wr_mask(int'(idx_i)));
    end
  end

  assign rdata_o    = in_range ? regs[idx_i[IW-1:0]] : 8'h00;
  assign cnt_o      = regs[IDX_CNT];
  assign mode_o     = regs[IDX_MODE];
  assign en_o       = regs[IDX_EN][NOUT-1:0];
  assign stop_sel_o = regs[IDX_STOP][NOUT-1:0];
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target import smb_cfg_pkg::*; #(
  parameter int unsigned NOUT    = 8,
  parameter logic [7:0]  WR_ADDR = 8'hDC,
  parameter logic [3:0]  REV_ID  = 4'h2,
  parameter logic [7:0]  DEV_ID  = 8'h81
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  output logic            pwrdn_hiz_o,
  output logic            halt_hiz_o,
  output logic            bw_low_o,
  output logic            pll_mode_o,
  output logic            div_full_o,
  output logic [NOUT-1:0] out_en_o,
  output logic [NOUT-1:0] stoppable_o
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  smb_state_t state, nxt;
  logic [3:0] bit_cnt;
  logic [7:0] sh, tx_sh, idx, left, rdata, cnt, mode;
  logic       ack_q;
  logic       start_w, stop_w, rise_w, fall_w, wr_en;

  smb_cond_det u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  assign wr_en = (state == ST_WDATA) && fall_w && (bit_cnt == 4'd8) &&
                 (left != 8'd0) && !start_w && !stop_w;

  smb_regfile #(.NOUT(NOUT), .REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .idx_i(idx), .wdata_i(sh),
    .rdata_o(rdata), .cnt_o(cnt), .mode_o(mode),
    .en_o(out_en_o), .stop_sel_o(stoppable_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      bit_cnt <= '0;
      sh      <= '0;
      tx_sh   <= '0;
      idx     <= '0;
      left    <= '0;
      ack_q   <= 1'b0;
    end else if (start_w) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
    end else if (stop_w) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
          if (rise_w && bit_cnt != 4'd8) begin
            sh      <= {sh[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (fall_w && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            state   <= ST_ACK;
            ack_q   <= 1'b1;
            case (state)
              ST_ADDR:
                if (sh == WR_ADDR)      nxt <= ST_CMD;
                else if (sh == RD_ADDR) nxt <= ST_TX;
                else begin ack_q <= 1'b0; nxt <= ST_IDLE; end
              ST_CMD: begin idx  <= sh; nxt <= ST_CNT;   end
              ST_CNT: begin left <= sh; nxt <= ST_WDATA; end
              default:
                if (left != 8'd0) begin
                  idx  <= idx + 8'd1;
                  left <= left - 8'd1;
                  nxt  <= ST_WDATA;
                end else begin
                  ack_q <= 1'b0;
                  nxt   <= ST_IDLE;
                end
            endcase
          end
        end
        ST_ACK: if (fall_w) begin
          if (!ack_q) state <= ST_IDLE;
          else begin
            state <= nxt;
            if (nxt == ST_TX) tx_sh <= cnt;  // count byte leads the read stream
          end
        end
        ST_TX: if (fall_w) begin
          if (bit_cnt == 4'd7) begin
            bit_cnt <= '0;
            state   <= ST_HACK;
          end else begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end
        ST_HACK: begin
          if (rise_w) ack_q <= ~sda_i;
          else if (fall_w) begin
            if (ack_q) begin
              tx_sh <= rdata;
              idx   <= idx + 8'd1;
              state <= ST_TX;
            end else state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o    = (state == ST_ACK && ack_q) || (state == ST_TX && !tx_sh[7]);
  assign pwrdn_hiz_o = mode[7];
  assign halt_hiz_o  = mode[6];
  assign bw_low_o    = mode[2];
  assign pll_mode_o  = mode[1];
  assign div_full_o  = mode[0];
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk import smb_cfg_pkg::*; #(
  parameter int unsigned NOUT = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_i,
  input logic            sda_oe_o,
  input logic [NOUT-1:0] out_en_o,
  input logic            start_det,
  input logic            stop_det,
  input smb_state_t      st,
  input logic [3:0]      bit_cnt
);
  // R10
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st == ST_ADDR && bit_cnt == 4'd0));
  // R4
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
  // R2
  cfg_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_en_o) |-> !scl_i);
endmodule

bind smb_cfg_target smb_cfg_target_chk #(.NOUT(NOUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .out_en_o(out_en_o), .start_det(start_w), .stop_det(stop_w),
  .st(state), .bit_cnt(bit_cnt)
);

// File: tb/smb_cfg_target_test.sv
`timescale 1ns/1ps
module smb_cfg_target_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic sda_line;
  logic sda_oe, pwrdn_hiz, halt_hiz, bw_low, pll_mode, div_full;
  logic [7:0] out_en, stoppable;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = host_sda & ~sda_oe;

  smb_cfg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pwrdn_hiz_o(pwrdn_hiz), .halt_hiz_o(halt_hiz),
    .bw_low_o(bw_low), .pll_mode_o(pll_mode), .div_full_o(div_full),
    .out_en_o(out_en), .stoppable_o(stoppable)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; hold(); host_scl = 1'b1; hold();
    host_sda = 1'b0; hold(); host_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hold(); host_scl = 1'b1; hold(); host_sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; hold(); host_scl = 1'b1; hold(); host_scl = 1'b0; hold();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    host_sda = 1'b1; hold(); host_scl = 1'b1; hold();
    ack = ~sda_line;
    host_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); host_scl = 1'b1; hold(); b[i] = sda_line; host_scl = 1'b0;
    end
    hold(); host_sda = nack; hold(); host_scl = 1'b1; hold(); host_scl = 1'b0; hold();
    host_sda = 1'b1;
  endtask

  task automatic wr_burst(input string req, input logic [7:0] idx, input logic [7:0] cnt,
                          input logic [7:0] d [], input int nack_from);
    logic a;
    bus_start();
    send_byte(8'hDC, a); chk(req, 8'(a), 8'h01);
    send_byte(idx, a);   chk(req, 8'(a), 8'h01);
    send_byte(cnt, a);   chk(req, 8'(a), 8'h01);
    foreach (d[i]) begin
      send_byte(d[i], a);
      chk(req, 8'(a), (i >= nack_from) ? 8'h00 : 8'h01);
    end
    bus_stop();
  endtask

  task automatic rd_burst(input string req, input logic [7:0] idx, input logic [7:0] exp []);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, a); chk(req, 8'(a), 8'h01);
    send_byte(idx, a);   chk(req, 8'(a), 8'h01);
    bus_start();
    send_byte(8'hDD, a); chk(req, 8'(a), 8'h01);
    foreach (exp[i]) begin
      recv_byte(b, (i == exp.size() - 1));
      chk(req, b, exp[i]);
    end
    bus_stop();
    chk({req, " release"}, 8'(sda_oe), 8'h00);
  endtask

  task automatic t_reset();  // R5 R11
    chk("R5 R11 mode", {pwrdn_hiz, halt_hiz, bw_low, pll_mode, div_full, 3'b0}, 8'h38);
    chk("R5 R11 out_en", out_en, 8'hFF);
    chk("R5 R11 stoppable", stoppable, 8'h00);
    chk("R10 idle", 8'(sda_oe), 8'h00);
  endtask

  task automatic t_read_all();  // R4 R5 R7 R6
    rd_burst("R4 R5 R7 read-all", 8'h00, '{8'h07, 8'h07, 8'hFF, 8'h00, 8'h00, 8'h21, 8'h81, 8'h07});
  endtask

  task automatic t_write_fields();  // R2 R11
    wr_burst("R2 write", 8'h00, 8'h03, '{8'hC0, 8'h00, 8'hAA}, 99);
    chk("R11 mode", {pwrdn_hiz, halt_hiz, bw_low, pll_mode, div_full, 3'b0}, 8'hC0);
    chk("R2 R11 out_en", out_en, 8'h00);
    chk("R2 R11 stoppable", stoppable, 8'hAA);
  endtask

  task automatic t_reserved();  // R6
    wr_burst("R6 write", 8'h00, 8'h01, '{8'h3F}, 99);
    rd_burst("R6 readback", 8'h00, '{8'h07, 8'h07, 8'h00, 8'hAA, 8'h00});
  endtask

  task automatic t_readonly();  // R7
    wr_burst("R7 write", 8'h04, 8'h02, '{8'h55, 8'h66}, 99);
    rd_burst("R7 readback", 8'h04, '{8'h07, 8'h21, 8'h81});
  endtask

  task automatic t_overrun();  // R3
    wr_burst("R3 overrun", 8'h01, 8'h01, '{8'h5A, 8'h33}, 1);
    chk("R3 out_en", out_en, 8'h5A);
    chk("R3 stoppable untouched", stoppable, 8'hAA);
  endtask

  task automatic t_foreign();  // R1
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign addr", 8'(a), 8'h00);
    send_byte(8'h02, a); chk("R1 ignored byte", 8'(a), 8'h00);
    send_byte(8'h11, a); chk("R1 ignored byte", 8'(a), 8'h00);
    bus_stop();
    chk("R1 stoppable untouched", stoppable, 8'hAA);
  endtask

  task automatic t_high_index();  // R8 R4
    wr_burst("R4 count write", 8'h06, 8'h01, '{8'h03}, 99);
    rd_burst("R8 R4 idx7", 8'h07, '{8'h03, 8'h00, 8'h00});
    rd_burst("R8 idx200", 8'd200, '{8'h03, 8'h00});
  endtask

  task automatic t_restart();  // R9
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, a); send_byte(8'h01, a); send_byte(8'h02, a);
    send_bits(8'h00, 4);
    bus_start();
    send_byte(8'hDD, a); chk("R9 restart addr", 8'(a), 8'h01);
    recv_byte(b, 1'b0); chk("R9 count", b, 8'h03);
    recv_byte(b, 1'b1); chk("R9 data", b, 8'h5A);
    bus_stop();
    chk("R9 no write", out_en, 8'h5A);
    chk("R9 R10 released", 8'(sda_oe), 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_all();
    t_write_fields();
    t_reserved();
    t_readonly();
    t_overrun();
    t_foreign();
    t_high_index();
    t_restart();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule